// File: doc/BRIEF.md
# Interpacket Gap Timer with Override

This block sets the minimum idle time between two packets sent back to back on a USB 2.0 host port. It runs in the UTMI clock domain. When the transmit path signals the end of a packet, the block drops its transmit-permit output for a set number of clocks and then raises it again. The length of that gap depends on the link speed, full or high, that applies to the packet that just ended.

Each speed has an 8-bit override taken from a control register. In the register word the full-speed field is bits 19:12 and the high-speed field is bits 11:4. An override of zero selects a built-in default, and so does device mode. A non-zero high-speed override in host mode also forces the line-check-disable status to zero. Speed, mode and override values are all captured when a packet ends, so a change during a gap only applies to the next packet.

Top module: `ipg_timer`

## Requirements
- R1: After reset, and before any tx_end_i pulse, tx_allowed_o is 1.
- R2: In host mode with a zero override for the captured speed, the gap is the built-in default: 8 clocks at high speed (hs_speed_i=1) and 12 clocks at full speed (hs_speed_i=0).
- R3: In host mode with a non-zero override N for the captured speed, tx_allowed_o is 0 for exactly N clocks. The low period begins on the first clock after the edge that samples tx_end_i high.
- R4: In device mode (host_en_i=0), the default gap is used and both override inputs are ignored.
- R5: linechk_dis_o equals lc_dis_cfg_i, except that it is 0 whenever host_en_i=1 and hs_ovr_i is non-zero.
- R6: A change of fs_ovr_i or hs_ovr_i while a gap is running leaves that gap's length unchanged.
- R7: A change of hs_speed_i or host_en_i while a gap is running leaves that gap's length unchanged.
- R8: A tx_end_i pulse during a running gap restarts the gap, using the values sampled at that new pulse.
- R9: Once a gap has run out, tx_allowed_o stays 1 until the next tx_end_i pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | UTMI clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_end_i | input | 1 | One-clock pulse at the end of a transmitted packet |
| hs_speed_i | input | 1 | Link speed: 1 is high speed, 0 is full speed |
| host_en_i | input | 1 | 1 enables host mode, which allows the overrides to take effect |
| fs_ovr_i | input | 8 | Full-speed gap override, control bits 19:12 |
| hs_ovr_i | input | 8 | High-speed gap override, control bits 11:4 |
| lc_dis_cfg_i | input | 1 | Configured line-check-disable setting |
| tx_allowed_o | output | 1 | 1 when a new packet may be sent |
| linechk_dis_o | output | 1 | Effective line-check-disable status |

## Verification
Two events can fall in the same clock: a gap running out and a new tx_end_i pulse arriving. Override, speed or mode inputs can also change in the same clock that a gap starts or ends. Random stimulus sends pulses at short random intervals and changes the inputs on every clock. This produces restarts during a gap and pulses on the exact clock a gap expires. A bench model that holds the remaining count judges tx_allowed_o on every clock. Directed cases measure the length of each low period with inputs changed during the gap, and the line-check status is compared after every change of its inputs.

// File: rtl/ipg_pkg.sv
package ipg_pkg;
    typedef enum logic {
        SPD_FULL = 1'b0,
        SPD_HIGH = 1'b1
    } speed_e;

    localparam int unsigned NUM_SPEEDS = 2;
endpackage

// File: rtl/ipg_gap_select.sv
module ipg_gap_select #(
    parameter int unsigned W      = 8,
    parameter int unsigned DEF_HS = 8,
    parameter int unsigned DEF_FS = 12
) (
    input  logic           host_en_i,
    input  ipg_pkg::speed_e speed_i,
    input  logic [W-1:0]   fs_ovr_i,
    input  logic [W-1:0]   hs_ovr_i,
    output logic [W-1:0]   gap_o
);
    localparam int unsigned N = ipg_pkg::NUM_SPEEDS;

    logic [W-1:0] ovr  [N];
    logic [W-1:0] pick [N];

    assign ovr[0] = fs_ovr_i;
    assign ovr[1] = hs_ovr_i;

    for (genvar i = 0; i < N; i++) begin : g_speed
        localparam logic [W-1:0] DEF_V = (i == 1) ? W'(DEF_HS) : W'(DEF_FS);
        always_comb begin
            if (host_en_i && (ovr[i] != '0)) begin
                pick[i] = ovr[i];
            end else begin
                pick[i] = DEF_V;
            end
        end
    end

    assign gap_o = (speed_i == ipg_pkg::SPD_HIGH) ? pick[1] : pick[0];
endmodule

// File: rtl/ipg_gap_counter.sv
module ipg_gap_counter #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [W-1:0] gap_i,
    output logic         busy_o,
    output logic [W-1:0] cnt_o,
    output logic [W-1:0] gap_o
);
    typedef struct packed {
        logic         busy;
        logic [W-1:0] cnt;
        logic [W-1:0] gap;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.busy = 1'b1;
            st_d.cnt  = W'(1);
            st_d.gap  = gap_i;
        end else if (st_q.busy) begin
            if (st_q.cnt >= st_q.gap) begin
                st_d.busy = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt + W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o = st_q.busy;
    assign cnt_o  = st_q.cnt;
    assign gap_o  = st_q.gap;
endmodule

// File: rtl/ipg_lc_gate.sv
module ipg_lc_gate #(
    parameter int unsigned W = 8
) (
    input  logic         host_en_i,
    input  logic [W-1:0] hs_ovr_i,
    input  logic         lc_dis_cfg_i,
    output logic         lc_dis_o
);
    logic hs_forced;

    always_comb begin
        hs_forced = host_en_i && (hs_ovr_i != '0);
        lc_dis_o  = hs_forced ? 1'b0 : lc_dis_cfg_i;
    end
endmodule

// File: rtl/ipg_timer.sv
module ipg_timer #(
    parameter int unsigned GAP_W  = 8,
    parameter int unsigned DEF_HS = 8,
    parameter int unsigned DEF_FS = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_end_i,
    input  logic             hs_speed_i,
    input  logic             host_en_i,
    input  logic [GAP_W-1:0] fs_ovr_i,
    input  logic [GAP_W-1:0] hs_ovr_i,
    input  logic             lc_dis_cfg_i,
    output logic             tx_allowed_o,
    output logic             linechk_dis_o
);
    ipg_pkg::speed_e  speed;
    logic [GAP_W-1:0] gap_sel;
    logic             busy_q;
    logic [GAP_W-1:0] cnt_q;
    logic [GAP_W-1:0] gap_q;

    assign speed = hs_speed_i ? ipg_pkg::SPD_HIGH : ipg_pkg::SPD_FULL;

    ipg_gap_select #(
        .W      (GAP_W),
        .DEF_HS (DEF_HS),
        .DEF_FS (DEF_FS)
    ) u_sel (
        .host_en_i (host_en_i),
        .speed_i   (speed),
        .fs_ovr_i  (fs_ovr_i),
        .hs_ovr_i  (hs_ovr_i),
        .gap_o     (gap_sel)
    );

    ipg_gap_counter #(
        .W (GAP_W)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (tx_end_i),
        .gap_i   (gap_sel),
        .busy_o  (busy_q),
        .cnt_o   (cnt_q),
        .gap_o   (gap_q)
    );

    ipg_lc_gate #(
        .W (GAP_W)
    ) u_lc (
        .host_en_i    (host_en_i),
        .hs_ovr_i     (hs_ovr_i),
        .lc_dis_cfg_i (lc_dis_cfg_i),
        .lc_dis_o     (linechk_dis_o)
    );

    assign tx_allowed_o = !busy_q;
endmodule

// File: rtl/ipg_timer_chk.sv
module ipg_timer_chk #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         tx_end_i,
    input logic         host_en_i,
    input logic [W-1:0] hs_ovr_i,
    input logic         tx_allowed_o,
    input logic         linechk_dis_o,
    input logic         busy_q,
    input logic [W-1:0] cnt_q,
    input logic [W-1:0] gap_q
);
    p_gap_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_end_i |=> !tx_allowed_o);

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> ((cnt_q <= gap_q) && (gap_q != '0)));

    p_gap_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !tx_end_i) |=> $stable(gap_q));

    p_lc_forced_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (host_en_i && (hs_ovr_i != '0)) |-> !linechk_dis_o);

    p_gap_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && (cnt_q == gap_q) && !tx_end_i) |=> tx_allowed_o);

    p_idle_stays_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_allowed_o && !tx_end_i) |=> tx_allowed_o);
endmodule

bind ipg_timer ipg_timer_chk #(.W(GAP_W)) u_chk (.*);

// File: tb/ipg_timer_bench.sv
module ipg_timer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tx_end = 1'b0;
    logic         hs = 1'b0;
    logic         host = 1'b0;
    logic [W-1:0] fs_ovr = '0;
    logic [W-1:0] hs_ovr = '0;
    logic         lc_cfg = 1'b0;
    logic         tx_allowed;
    logic         lc_dis;

    int checks = 0;
    int errors = 0;
    int m_rem = 0;
    bit model_on = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ipg_timer u_ipg_timer (
        .clk           (clk),
        .rst_n         (rst_n),
        .tx_end_i      (tx_end),
        .hs_speed_i    (hs),
        .host_en_i     (host),
        .fs_ovr_i      (fs_ovr),
        .hs_ovr_i      (hs_ovr),
        .lc_dis_cfg_i  (lc_cfg),
        .tx_allowed_o  (tx_allowed),
        .linechk_dis_o (linechk_dis_o_w)
    );
    logic linechk_dis_o_w;
    assign lc_dis = linechk_dis_o_w;

    function automatic int exp_gap(bit h, bit s, logic [W-1:0] f, logic [W-1:0] o);
        if (s) return (h && o != 0) ? int'(o) : 8;
        return (h && f != 0) ? int'(f) : 12;
    endfunction

    function automatic bit exp_lc(bit h, logic [W-1:0] o, bit c);
        return (h && o != 0) ? 1'b0 : c;
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (rst_n) begin
            if (tx_end) m_rem <= exp_gap(host, hs, fs_ovr, hs_ovr);
            else if (m_rem > 0) m_rem <= m_rem - 1;
        end
    end

    always @(negedge clk) begin
        if (model_on) check("R9/R8 tx_allowed vs model", int'(tx_allowed), int'(m_rem == 0));
    end

    task automatic measure(string tag, bit h, bit s, logic [W-1:0] f, logic [W-1:0] o,
                           bit mid, bit h2, bit s2, logic [W-1:0] f2, logic [W-1:0] o2, int exp);
        int n = 0;
        @(negedge clk);
        host = h; hs = s; fs_ovr = f; hs_ovr = o; tx_end = 1'b1;
        @(negedge clk);
        tx_end = 1'b0;
        if (mid) begin host = h2; hs = s2; fs_ovr = f2; hs_ovr = o2; end
        while (!tx_allowed && n < 400) begin
            n++;
            @(negedge clk);
        end
        check(tag, n, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL R9 watchdog actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(1234);
        #(CLK_PERIOD * 3);
        @(negedge clk);
        check("R1 tx_allowed after reset", int'(tx_allowed), 1);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R1 tx_allowed idle", int'(tx_allowed), 1);
        model_on = 1'b1;

        measure("R2 HS default", 1, 1, 8'd0, 8'd0, 0, 0, 0, 0, 0, 8);
        measure("R2 FS default", 1, 0, 8'd0, 8'd0, 0, 0, 0, 0, 0, 12);
        measure("R3 HS override 5", 1, 1, 8'd0, 8'd5, 0, 0, 0, 0, 0, 5);
        measure("R3 FS override 1", 1, 0, 8'd1, 8'd0, 0, 0, 0, 0, 0, 1);
        measure("R3 HS override 255", 1, 1, 8'd3, 8'd255, 0, 0, 0, 0, 0, 255);
        measure("R4 device HS", 0, 1, 8'd40, 8'd40, 0, 0, 0, 0, 0, 8);
        measure("R4 device FS", 0, 0, 8'd40, 8'd40, 0, 0, 0, 0, 0, 12);
        measure("R6 override change mid gap", 1, 1, 8'd0, 8'd20, 1, 1, 1, 8'd0, 8'd2, 20);
        measure("R7 speed change mid gap", 1, 0, 8'd30, 8'd3, 1, 1, 1, 8'd30, 8'd3, 30);
        measure("R7 host change mid gap", 1, 1, 8'd0, 8'd25, 1, 0, 1, 8'd0, 8'd25, 25);

        // R8: restart during a gap
        begin
            int n = 0;
            @(negedge clk);
            host = 1; hs = 1; hs_ovr = 8'd30; tx_end = 1'b1;
            @(negedge clk); tx_end = 1'b0;
            repeat (4) @(negedge clk);
            hs = 0; fs_ovr = 8'd6; tx_end = 1'b1;
            @(negedge clk); tx_end = 1'b0;
            while (!tx_allowed && n < 400) begin n++; @(negedge clk); end
            check("R8 restart length", n, 6);
        end

        // R9: pulse on the clock the gap expires
        begin
            int n = 0;
            @(negedge clk);
            host = 1; hs = 1; hs_ovr = 8'd3; tx_end = 1'b1;
            @(negedge clk); tx_end = 1'b0;
            repeat (2) @(negedge clk);
            tx_end = 1'b1; hs_ovr = 8'd4;
            @(negedge clk); tx_end = 1'b0;
            while (!tx_allowed && n < 400) begin n++; @(negedge clk); end
            check("R9 back-to-back length", n, 4);
            repeat (5) @(negedge clk);
            check("R9 stays allowed", int'(tx_allowed), 1);
        end

        // R5 directed
        @(negedge clk); host = 1; hs_ovr = 8'd7; lc_cfg = 1; #1;
        check("R5 forced low", int'(lc_dis), 0);
        @(negedge clk); host = 0; #1;
        check("R5 device pass", int'(lc_dis), 1);
        @(negedge clk); host = 1; hs_ovr = 8'd0; #1;
        check("R5 zero override pass", int'(lc_dis), 1);

        // random phase
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            tx_end = ($urandom_range(0, 9) == 0);
            if ($urandom_range(0, 3) == 0) hs = $urandom_range(0, 1);
            if ($urandom_range(0, 3) == 0) host = $urandom_range(0, 1);
            if ($urandom_range(0, 2) == 0) fs_ovr = ($urandom_range(0, 1) == 1) ? 8'($urandom_range(1, 20)) : 8'd0;
            if ($urandom_range(0, 2) == 0) hs_ovr = ($urandom_range(0, 1) == 1) ? 8'($urandom_range(1, 20)) : 8'd0;
            lc_cfg = $urandom_range(0, 1);
            #1;
            check("R5 random lc", int'(lc_dis), int'(exp_lc(host, hs_ovr, lc_cfg)));
        end
        @(negedge clk); tx_end = 1'b0;
        repeat (300) @(negedge clk);
        check("R9 idle at end", int'(tx_allowed), 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule